// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block sits beside the fetch stage and turns the current fetch PC, plus three predecode flags (unconditional, call, return), into a taken decision and the next fetch address. It keeps two pieces of state. The first is a table of saturating counters, selected by the PC with the byte offset removed. The second is a direct-mapped target table that holds a partial tag, the target address, and one valid bit per hardware thread. Return targets come from an external return stack through a top-of-stack input. Calls push their fall-through address onto that stack. Every fetch also emits a short record for an external prediction history queue.

The prediction is purely combinational from the fetch inputs, which are expected to come from a registered PC. Two write ports, driven at commit or after a mispredict, train the counters and install targets. A write becomes visible to lookups only after the next rising clock edge.

Top module: `bpred_front`

## Requirements
- R1: After reset every counter holds the weakly not-taken value 01. A conditional fetch then predicts not-taken, next_pc equals fetch_pc + 4, and no stack push or pop is requested.
- R2: A fetch with is_uncond=1 is taken in direction whatever its counter holds. If it is not a return and its target entry hits, next_pc is the stored target.
- R3: A conditional fetch is taken in direction when the MSB of its 2-bit counter is 1. A counter update with taken=1 increments the counter and saturates at 11. An update with taken=0 decrements it and saturates at 00.
- R4: A fetch with is_return=1 that is taken in direction sets ras_pop=1 and rec_used_ras=1. It is predicted taken with next_pc = ras_top, and the target table is not consulted. ras_pop and ras_push are never high together.
- R5: A non-return call that is taken in direction sets ras_push=1 with ras_push_addr = fetch_pc + 4, and sets rec_call=1. This happens even when its target lookup misses.
- R6: A non-return fetch that is taken in direction but misses in the target table is predicted not-taken. Whenever the final prediction is not-taken, next_pc = fetch_pc + 4.
- R7: Target validity is kept per thread. An entry installed by thread t hits only for fetch_tid = t. Installing into an index clears the valid bits of the other threads at that index.
- R8: The target table is indexed by fetch_pc[5:2] and tagged by fetch_pc[13:6]. A PC with the same index but a different tag misses.
- R9: A counter or target write is not seen by a lookup in the cycle it is presented. It is seen from the first rising edge after it.
- R10: A target write with btb_upd_taken=0 leaves the table unchanged.
- R11: With fetch_valid=0, pred_taken, ras_pop, ras_push and rec_valid are all 0, and next_pc = fetch_pc + 4.
- R12: The counter index is fetch_pc[7:2]. Training the counter for one PC does not change the prediction for the next sequential PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch lookup is presented |
| fetch_pc | input | 32 | Registered fetch PC |
| fetch_tid | input | 1 | Thread of the fetch |
| is_uncond | input | 1 | Predecode: unconditional control transfer |
| is_call | input | 1 | Predecode: call |
| is_return | input | 1 | Predecode: return |
| pred_taken | output | 1 | Final taken prediction |
| next_pc | output | 32 | Predicted next fetch address (also the predicted target) |
| ras_top | input | 32 | Top entry of the external return stack |
| ras_pop | output | 1 | Pop request to the return stack |
| ras_push | output | 1 | Push request to the return stack |
| ras_push_addr | output | 32 | Address to push (fetch_pc + 4) |
| rec_valid | output | 1 | History record is valid this cycle |
| rec_taken | output | 1 | Record: final prediction |
| rec_call | output | 1 | Record: a speculative push was made |
| rec_used_ras | output | 1 | Record: target came from the return stack |
| ctr_upd_valid | input | 1 | Counter training strobe |
| ctr_upd_pc | input | 32 | PC of the trained branch |
| ctr_upd_taken | input | 1 | Actual outcome |
| btb_upd_valid | input | 1 | Target write strobe |
| btb_upd_pc | input | 32 | PC of the branch to install |
| btb_upd_tid | input | 1 | Thread of the write |
| btb_upd_taken | input | 1 | Actual outcome; 0 suppresses the write |
| btb_upd_target | input | 32 | Corrected target |

## Verification
Lookup results (pred_taken, next_pc, the stack requests and the record) are combinational from the fetch inputs, so they are due in the same cycle. The bench drives fetch inputs just after a falling edge and samples them 1 ns later, well away from any rising edge. Training writes take effect one rising edge after they are presented. For these, the bench drives the write at a falling edge, removes it at the next falling edge, and only then looks up. In one scenario it also looks up while the write is still pending, to confirm that the old state is returned before the edge.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
   typedef enum logic [1:0] {
      SRC_FALL = 2'd0,
      SRC_TBL  = 2'd1,
      SRC_STK  = 2'd2
   } tgt_src_e;
endpackage

// File: rtl/bpred_ctr_table.sv
module bpred_ctr_table #(
   parameter int PC_W    = 32,
   parameter int OFF_W   = 2,
   parameter int ENTRIES = 64,
   parameter int CTR_W   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] rd_pc,
   output logic            rd_taken,
   input  logic            wr_en,
   input  logic [PC_W-1:0] wr_pc,
   input  logic            wr_taken
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam logic [CTR_W-1:0] CTR_MAX  = '1;
   localparam logic [CTR_W-1:0] CTR_MIN  = '0;
   localparam logic [CTR_W-1:0] CTR_INIT = {1'b0, {(CTR_W-1){1'b1}}};

   if (CTR_W < 2) begin : g_bad_ctr
      $error("CTR_W must be at least 2");
   end
   if ((ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_depth
      $error("counter ENTRIES must be a power of two");
   end

   logic [CTR_W-1:0] ctr_q [ENTRIES];
   logic [IDX_W-1:0] rd_idx, wr_idx;
   logic [CTR_W-1:0] cur, nxt;
   logic             unused_pc;

   assign rd_idx    = rd_pc[OFF_W +: IDX_W];
   assign wr_idx    = wr_pc[OFF_W +: IDX_W];
   assign rd_taken  = ctr_q[rd_idx][CTR_W-1];
   assign unused_pc = ^{rd_pc, wr_pc};

   always_comb begin
      cur = ctr_q[wr_idx];
      nxt = cur;
      if (wr_taken && cur != CTR_MAX)
         nxt = cur + 1'b1;
      else if (!wr_taken && cur != CTR_MIN)
         nxt = cur - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++)
            ctr_q[i] <= CTR_INIT;
      end else if (wr_en) begin
         ctr_q[wr_idx] <= nxt;
      end
   end
endmodule

// File: rtl/bpred_tgt_table.sv
module bpred_tgt_table #(
   parameter int PC_W    = 32,
   parameter int OFF_W   = 2,
   parameter int ENTRIES = 16,
   parameter int TAG_W   = 8,
   parameter int THREADS = 2,
   parameter int TID_W   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PC_W-1:0]  rd_pc,
   input  logic [TID_W-1:0] rd_tid,
   output logic             rd_hit,
   output logic [PC_W-1:0]  rd_target,
   input  logic             wr_en,
   input  logic [PC_W-1:0]  wr_pc,
   input  logic [TID_W-1:0] wr_tid,
   input  logic [PC_W-1:0]  wr_target
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int TAG_LO = OFF_W + IDX_W;

   if ((ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_depth
      $error("target ENTRIES must be a power of two");
   end
   if (TAG_LO + TAG_W > PC_W) begin : g_bad_tag
      $error("tag field exceeds the PC width");
   end
   if ((THREADS & (THREADS - 1)) != 0) begin : g_bad_thr
      $error("THREADS must be a power of two");
   end

   logic [ENTRIES-1:0] valid_q [THREADS];
   logic [PC_W-1:0]    target_q [ENTRIES];
   logic [IDX_W-1:0]   rd_idx, wr_idx;
   logic               tag_ok;
   logic               unused_pc;

   assign rd_idx    = rd_pc[OFF_W +: IDX_W];
   assign wr_idx    = wr_pc[OFF_W +: IDX_W];
   assign rd_target = target_q[rd_idx];
   assign rd_hit    = valid_q[rd_tid][rd_idx] && tag_ok;
   assign unused_pc = ^{rd_pc, wr_pc};

   if (TAG_W > 0) begin : g_tagged
      logic [TAG_W-1:0] tag_q [ENTRIES];
      assign tag_ok = (tag_q[rd_idx] == rd_pc[TAG_LO +: TAG_W]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++)
               tag_q[i] <= '0;
         end else if (wr_en) begin
            tag_q[wr_idx] <= wr_pc[TAG_LO +: TAG_W];
         end
      end
   end else begin : g_untagged
      assign tag_ok = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < THREADS; t++)
            valid_q[t] <= '0;
         for (int i = 0; i < ENTRIES; i++)
            target_q[i] <= '0;
      end else if (wr_en) begin
         target_q[wr_idx] <= wr_target;
         for (int t = 0; t < THREADS; t++)
            valid_q[t][wr_idx] <= (TID_W'(t) == wr_tid);
      end
   end
endmodule

// File: rtl/bpred_front.sv
module bpred_front #(
   parameter int PC_W        = 32,
   parameter int INST_BYTES  = 4,
   parameter int CTR_ENTRIES = 64,
   parameter int CTR_W       = 2,
   parameter int TGT_ENTRIES = 16,
   parameter int TAG_W       = 8,
   parameter int THREADS     = 2,
   parameter int TID_W       = (THREADS > 1) ? $clog2(THREADS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fetch_valid,
   input  logic [PC_W-1:0]  fetch_pc,
   input  logic [TID_W-1:0] fetch_tid,
   input  logic             is_uncond,
   input  logic             is_call,
   input  logic             is_return,
   output logic             pred_taken,
   output logic [PC_W-1:0]  next_pc,
   input  logic [PC_W-1:0]  ras_top,
   output logic             ras_pop,
   output logic             ras_push,
   output logic [PC_W-1:0]  ras_push_addr,
   output logic             rec_valid,
   output logic             rec_taken,
   output logic             rec_call,
   output logic             rec_used_ras,
   input  logic             ctr_upd_valid,
   input  logic [PC_W-1:0]  ctr_upd_pc,
   input  logic             ctr_upd_taken,
   input  logic             btb_upd_valid,
   input  logic [PC_W-1:0]  btb_upd_pc,
   input  logic [TID_W-1:0] btb_upd_tid,
   input  logic             btb_upd_taken,
   input  logic [PC_W-1:0]  btb_upd_target
);
   import bpred_pkg::*;

   localparam int OFF_W = $clog2(INST_BYTES);

   if ((INST_BYTES & (INST_BYTES - 1)) != 0) begin : g_bad_inst
      $error("INST_BYTES must be a power of two");
   end

   logic            ctr_says_taken;
   logic            tbl_hit;
   logic [PC_W-1:0] tbl_target;
   logic [PC_W-1:0] fall_pc;
   logic            dir_taken;
   tgt_src_e        src;

   bpred_ctr_table #(
      .PC_W(PC_W), .OFF_W(OFF_W), .ENTRIES(CTR_ENTRIES), .CTR_W(CTR_W)
   ) ctr_i (
      .clk(clk), .rst_n(rst_n),
      .rd_pc(fetch_pc), .rd_taken(ctr_says_taken),
      .wr_en(ctr_upd_valid), .wr_pc(ctr_upd_pc), .wr_taken(ctr_upd_taken)
   );

   bpred_tgt_table #(
      .PC_W(PC_W), .OFF_W(OFF_W), .ENTRIES(TGT_ENTRIES), .TAG_W(TAG_W),
      .THREADS(THREADS), .TID_W(TID_W)
   ) tgt_i (
      .clk(clk), .rst_n(rst_n),
      .rd_pc(fetch_pc), .rd_tid(fetch_tid),
      .rd_hit(tbl_hit), .rd_target(tbl_target),
      .wr_en(btb_upd_valid && btb_upd_taken), .wr_pc(btb_upd_pc),
      .wr_tid(btb_upd_tid), .wr_target(btb_upd_target)
   );

   assign fall_pc   = fetch_pc + PC_W'(INST_BYTES);
   assign dir_taken = fetch_valid && (is_uncond || ctr_says_taken);

   always_comb begin
      src = SRC_FALL;
      if (dir_taken) begin
         if (is_return)
            src = SRC_STK;
         else if (tbl_hit)
            src = SRC_TBL;
      end
   end

   always_comb begin
      unique case (src)
         SRC_STK: next_pc = ras_top;
         SRC_TBL: next_pc = tbl_target;
         default: next_pc = fall_pc;
      endcase
   end

   assign pred_taken    = (src != SRC_FALL);
   assign ras_pop       = dir_taken && is_return;
   assign ras_push      = dir_taken && !is_return && is_call;
   assign ras_push_addr = fall_pc;
   assign rec_valid     = fetch_valid;
   assign rec_taken     = pred_taken;
   assign rec_call      = ras_push;
   assign rec_used_ras  = ras_pop;
endmodule

// File: rtl/bpred_front_chk.sv
module bpred_front_chk #(
   parameter int PC_W       = 32,
   parameter int INST_BYTES = 4,
   parameter int TID_W      = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fetch_valid,
   input logic [PC_W-1:0]  fetch_pc,
   input logic             is_uncond,
   input logic             is_call,
   input logic             is_return,
   input logic             pred_taken,
   input logic [PC_W-1:0]  next_pc,
   input logic [PC_W-1:0]  ras_top,
   input logic             ras_pop,
   input logic             ras_push,
   input logic [PC_W-1:0]  ras_push_addr,
   input logic             rec_valid,
   input logic             rec_taken,
   input logic             rec_call,
   input logic             rec_used_ras
);
   localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

   // R4: stack requests are exclusive
   p_stack_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(ras_pop && ras_push));

   // R4: a pop always yields a taken prediction to the stack top
   p_pop_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ras_pop |-> (pred_taken && next_pc == ras_top && rec_used_ras));

   // R2: an unconditional return is always taken
   p_uncond_ret_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && is_uncond && is_return) |-> pred_taken);

   // R5: push address and record flag accompany a push
   p_push_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ras_push |-> (ras_push_addr == fetch_pc + STEP && rec_call && is_call));

   // R6: a not-taken prediction falls through
   p_fall_thru_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> (next_pc == fetch_pc + STEP));

   // R11: an idle fetch requests nothing
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_valid |-> (!pred_taken && !ras_pop && !ras_push && !rec_valid));

   // R6: record mirrors the final decision
   p_rec_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> (rec_taken == pred_taken));
endmodule

bind bpred_front bpred_front_chk #(
   .PC_W(PC_W), .INST_BYTES(INST_BYTES), .TID_W(TID_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
   .is_uncond(is_uncond), .is_call(is_call), .is_return(is_return),
   .pred_taken(pred_taken), .next_pc(next_pc), .ras_top(ras_top),
   .ras_pop(ras_pop), .ras_push(ras_push), .ras_push_addr(ras_push_addr),
   .rec_valid(rec_valid), .rec_taken(rec_taken), .rec_call(rec_call),
   .rec_used_ras(rec_used_ras)
);

// File: tb/bpred_front_tb_top.sv
module bpred_front_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid = 0, is_uncond = 0, is_call = 0, is_return = 0;
   logic [31:0] fetch_pc = '0, ras_top = '0;
   logic [0:0]  fetch_tid = '0, btb_upd_tid = '0;
   logic        pred_taken, ras_pop, ras_push, rec_valid, rec_taken, rec_call, rec_used_ras;
   logic [31:0] next_pc, ras_push_addr;
   logic        ctr_upd_valid = 0, ctr_upd_taken = 0;
   logic [31:0] ctr_upd_pc = '0;
   logic        btb_upd_valid = 0, btb_upd_taken = 0;
   logic [31:0] btb_upd_pc = '0, btb_upd_target = '0;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   bpred_front dut_i (
      .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .fetch_tid(fetch_tid), .is_uncond(is_uncond), .is_call(is_call),
      .is_return(is_return), .pred_taken(pred_taken), .next_pc(next_pc),
      .ras_top(ras_top), .ras_pop(ras_pop), .ras_push(ras_push),
      .ras_push_addr(ras_push_addr), .rec_valid(rec_valid), .rec_taken(rec_taken),
      .rec_call(rec_call), .rec_used_ras(rec_used_ras),
      .ctr_upd_valid(ctr_upd_valid), .ctr_upd_pc(ctr_upd_pc),
      .ctr_upd_taken(ctr_upd_taken), .btb_upd_valid(btb_upd_valid),
      .btb_upd_pc(btb_upd_pc), .btb_upd_tid(btb_upd_tid),
      .btb_upd_taken(btb_upd_taken), .btb_upd_target(btb_upd_target)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // present a lookup after a falling edge and let it settle
   task automatic look(input logic [31:0] pc, input logic tid, input logic u,
                       input logic c, input logic r);
      @(negedge clk);
      fetch_valid = 1; fetch_pc = pc; fetch_tid = tid;
      is_uncond = u; is_call = c; is_return = r;
      #1;
   endtask

   task automatic train_ctr(input logic [31:0] pc, input logic tk);
      @(negedge clk);
      ctr_upd_valid = 1; ctr_upd_pc = pc; ctr_upd_taken = tk;
      @(negedge clk);
      ctr_upd_valid = 0;
   endtask

   task automatic install(input logic [31:0] pc, input logic tid,
                          input logic tk, input logic [31:0] tgt);
      @(negedge clk);
      btb_upd_valid = 1; btb_upd_pc = pc; btb_upd_tid = tid;
      btb_upd_taken = tk; btb_upd_target = tgt;
      @(negedge clk);
      btb_upd_valid = 0;
   endtask

   task automatic t_reset;
      look(32'h100, 0, 0, 0, 0);
      chk("R1 taken", {31'b0, pred_taken}, 0);
      chk("R1 next_pc", next_pc, 32'h104);
      chk("R1 push/pop", {30'b0, ras_push, ras_pop}, 0);
      chk("R1 rec_valid", {31'b0, rec_valid}, 1);
   endtask

   task automatic t_idle;
      look(32'h100, 0, 1, 1, 1);
      fetch_valid = 0; #1;
      chk("R11 outputs", {28'b0, pred_taken, ras_pop, ras_push, rec_valid}, 0);
      chk("R11 next_pc", next_pc, 32'h104);
   endtask

   task automatic t_miss;
      look(32'h100, 0, 1, 0, 0);
      chk("R6 miss taken", {31'b0, pred_taken}, 0);
      chk("R6 miss next_pc", next_pc, 32'h104);
   endtask

   task automatic t_uncond;
      install(32'h100, 0, 1, 32'h800);
      look(32'h100, 0, 1, 0, 0);
      chk("R2 uncond taken", {31'b0, pred_taken}, 1);
      chk("R2 uncond target", next_pc, 32'h800);
      look(32'h100, 0, 0, 0, 0);
      chk("R3 cond weak counter", {31'b0, pred_taken}, 0);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      btb_upd_valid = 1; btb_upd_pc = 32'h204; btb_upd_tid = 0;
      btb_upd_taken = 1; btb_upd_target = 32'h900;
      fetch_valid = 1; fetch_pc = 32'h204; fetch_tid = 0;
      is_uncond = 1; is_call = 0; is_return = 0;
      #1;
      chk("R9 before edge", {31'b0, pred_taken}, 0);
      @(negedge clk);
      btb_upd_valid = 0;
      #1;
      chk("R9 after edge", next_pc, 32'h900);
   endtask

   task automatic t_threads;
      look(32'h100, 1, 1, 0, 0);
      chk("R7 other thread miss", {31'b0, pred_taken}, 0);
      install(32'h100, 1, 1, 32'hA00);
      look(32'h100, 1, 1, 0, 0);
      chk("R7 thread1 hit", next_pc, 32'hA00);
      look(32'h100, 0, 1, 0, 0);
      chk("R7 thread0 dropped", {31'b0, pred_taken}, 0);
   endtask

   task automatic t_tag;
      look(32'h140, 1, 1, 0, 0);
      chk("R8 alias miss", {31'b0, pred_taken}, 0);
   endtask

   task automatic t_nt_write;
      install(32'h140, 1, 0, 32'hB00);
      look(32'h100, 1, 1, 0, 0);
      chk("R10 entry kept", next_pc, 32'hA00);
      look(32'h140, 1, 1, 0, 0);
      chk("R10 no install", {31'b0, pred_taken}, 0);
   endtask

   task automatic t_counter;
      install(32'h208, 0, 1, 32'hD00);
      train_ctr(32'h204, 1);
      look(32'h204, 0, 0, 0, 0);
      chk("R3 one taken", next_pc, 32'h900);
      look(32'h208, 0, 0, 0, 0);
      chk("R12 neighbor unchanged", {31'b0, pred_taken}, 0);
      train_ctr(32'h204, 1);
      train_ctr(32'h204, 1);
      train_ctr(32'h204, 0);
      look(32'h204, 0, 0, 0, 0);
      chk("R3 saturate high", {31'b0, pred_taken}, 1);
      train_ctr(32'h204, 0);
      look(32'h204, 0, 0, 0, 0);
      chk("R3 down to weak", {31'b0, pred_taken}, 0);
      train_ctr(32'h204, 0);
      train_ctr(32'h204, 0);
      train_ctr(32'h204, 1);
      look(32'h204, 0, 0, 0, 0);
      chk("R3 saturate low", {31'b0, pred_taken}, 0);
      train_ctr(32'h204, 1);
      look(32'h204, 0, 0, 0, 0);
      chk("R3 climb back", {31'b0, pred_taken}, 1);
   endtask

   task automatic t_return;
      ras_top = 32'hC00;
      look(32'h300, 0, 1, 0, 1);
      chk("R4 ret target", next_pc, 32'hC00);
      chk("R4 ret flags", {28'b0, pred_taken, ras_pop, ras_push, rec_used_ras}, 4'b1101);
      look(32'h300, 0, 0, 0, 1);
      chk("R4 cond ret not taken", {30'b0, pred_taken, ras_pop}, 0);
   endtask

   task automatic t_call;
      look(32'h204, 0, 1, 1, 0);
      chk("R5 call target", next_pc, 32'h900);
      chk("R5 call push", {30'b0, ras_push, rec_call}, 2'b11);
      chk("R5 push addr", ras_push_addr, 32'h208);
      look(32'h400, 0, 1, 1, 0);
      chk("R5 call miss push", {30'b0, ras_push, pred_taken}, 2'b10);
      chk("R6 call miss next", next_pc, 32'h404);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      t_reset;
      t_idle;
      t_miss;
      t_uncond;
      t_same_cycle;
      t_threads;
      t_tag;
      t_nt_write;
      t_counter;
      t_return;
      t_call;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule